// File: doc/BRIEF.md
# Second-Level Cache Tag Store with Debug Access

This block holds the tags of a two-way, 1024-set second-level cache and serves two clients on one clock. The lookup client presents a 32-bit address and receives, one cycle later, a hit flag and the number of the way that matched. The debug client reads or writes one entry at a time. It uses a command word to choose direction and target, an address word to choose the set and the way, and a 32-bit data word that carries the tag image. The data side of the cache is only a stub here: one 32-bit word per line, so that a debug data access has a target.

Each entry keeps 17 tag bits. Sixteen come from address bits 31:16. The seventeenth duplicates address bit 15, which is also the top bit of the set index. A debug write stores that seventeenth bit exactly as it is given. If it disagrees with the top set-index bit of the entry it lands in, the entry can still be read back in full, but no lookup can ever hit it. Debug accesses win over lookups: a lookup that arrives together with a debug request is held for one cycle and then served.

Top module: `ltag_array`

## Requirements
- R1: After reset, `dbg_done`, `lk_done` and `lk_hit` are low, every entry is invalid, every lookup misses and a tag read returns valid bit 0.
- R2: A debug tag write stores `dbg_wdata[31:16]` as the tag, `dbg_wdata[15]` as the extra bit and `dbg_wdata[0]` as the valid bit. `dbg_wdata[14:1]` is ignored.
- R3: A debug request raises `dbg_done` for exactly the following cycle. A tag read returns in `dbg_rdata` in that cycle the tag at [31:16], the extra bit at [15], the way number at [2:1], the valid bit at [0], and zeros in [14:3].
- R4: A debug access uses `dbg_addr[15:6]` as the set and `dbg_addr[0]` as the way. `dbg_addr[31:16]` and `dbg_addr[5:1]` are ignored.
- R5: `dbg_cmd[0]` selects read (0) or write (1). `dbg_cmd[1]` selects the tag (0) or the data stub (1).
- R6: A debug data write stores the 32-bit word of the addressed line, and a debug data read returns it. A data access leaves tag, extra bit and valid bit unchanged.
- R7: A lookup uses `lk_addr[15:6]` as the set. A way hits when it is valid, its tag equals `lk_addr[31:16]` and its extra bit equals `lk_addr[15]`. The result appears in the cycle after the lookup is served, and `lk_way` reports the lowest hitting way.
- R8: An entry whose extra bit differs from the top bit of its set index reads back unchanged but never produces a hit.
- R9: A lookup issued in the same cycle as a debug request gives no result in the next cycle and is served one cycle later. It then sees the array as updated by that debug write.
- R10: A lookup request that arrives in the cycle a held lookup is being served is ignored.
- R11: `lk_hit` is high only together with `lk_done`, and `lk_way` is 0 whenever `lk_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both clients |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup address |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | 1 | Way that hit |
| dbg_req | input | 1 | Debug access request |
| dbg_cmd | input | 2 | Bit 0 write, bit 1 data target |
| dbg_addr | input | 32 | Debug set and way selection |
| dbg_wdata | input | 32 | Debug write word |
| dbg_done | output | 1 | Debug access completed |
| dbg_rdata | output | 32 | Debug read word |

## Verification
The hardest state to reach from the ports is a valid entry whose extra bit contradicts its set. Normal lookups never create one, because the lookup key takes bit 15 from the same address that picks the set. The stimulus therefore writes tags through the debug port and flips the extra bit on about a quarter of the writes. It uses a small pool of sets on both sides of the 511/512 boundary and a small pool of tags, so that later lookups often land on the corrupted entries. Lookups that collide with debug writes to the same key are mixed in, and sometimes a third lookup follows in the serve cycle. This checks that a held lookup sees the new contents and that the extra request is dropped.

// File: rtl/ltag_pkg.sv
package ltag_pkg;

  localparam int ADDR_W   = 32;
  localparam int TAG_W    = 16;
  localparam int TAG_LSB  = 16;
  localparam int XBIT_POS = 15;
  localparam int KEY_W    = TAG_W + 1;
  localparam int WORD_W   = 32;

  typedef enum logic {DIR_READ = 1'b0, DIR_WRITE = 1'b1} dir_e;
  typedef enum logic {TGT_TAG = 1'b0, TGT_DATA = 1'b1} tgt_e;

  // 17-bit comparison key taken from an address: tag bits then set MSB
  function automatic logic [KEY_W-1:0] addr_key(input logic [ADDR_W-1:0] a);
    return {a[TAG_LSB +: TAG_W], a[XBIT_POS]};
  endfunction

  // tag image as presented on the debug data word
  function automatic logic [WORD_W-1:0] tag_image(input logic [TAG_W-1:0] tag,
                                                  input logic xbit,
                                                  input logic [1:0] way,
                                                  input logic vld);
    return {tag, xbit, 12'h000, way, vld};
  endfunction

endpackage

// File: rtl/ltag_way_bank.sv
module ltag_way_bank #(
  parameter int SETS  = 1024,
  parameter int TAG_W = 16,
  parameter int DW    = 32,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tag_we,
  input  logic             data_we,
  input  logic [SET_W-1:0] wr_set,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_xbit,
  input  logic             wr_vld,
  input  logic [DW-1:0]    wr_data,
  input  logic [SET_W-1:0] a_set,
  output logic [TAG_W-1:0] a_tag,
  output logic             a_xbit,
  output logic             a_vld,
  output logic [DW-1:0]    a_data,
  input  logic [SET_W-1:0] b_set,
  output logic [TAG_W-1:0] b_tag,
  output logic             b_xbit,
  output logic             b_vld
);

  logic [TAG_W-1:0] tag_q  [SETS];
  logic [DW-1:0]    data_q [SETS];
  logic [SETS-1:0]  xbit_q;
  logic [SETS-1:0]  vld_q;

  always_ff @(posedge clk) begin
    if (tag_we) begin
      tag_q[wr_set]  <= wr_tag;
      xbit_q[wr_set] <= wr_xbit;
    end
    if (data_we) begin
      data_q[wr_set] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (tag_we) begin
      vld_q[wr_set] <= wr_vld;
    end
  end

  // debug read port
  assign a_tag  = tag_q[a_set];
  assign a_xbit = xbit_q[a_set];
  assign a_vld  = vld_q[a_set];
  assign a_data = data_q[a_set];

  // lookup read port
  assign b_tag  = tag_q[b_set];
  assign b_xbit = xbit_q[b_set];
  assign b_vld  = vld_q[b_set];

endmodule

// File: rtl/ltag_match.sv
module ltag_match
  import ltag_pkg::*;
#(
  parameter int WAYS = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [KEY_W-1:0]            key,
  input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  input  logic [WAYS-1:0]             way_xbit,
  input  logic [WAYS-1:0]             way_vld,
  output logic [WAYS-1:0]             hit_vec,
  output logic                        any_hit,
  output logic [WAY_W-1:0]            hit_way
);

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_cmp
      assign hit_vec[g] = way_vld[g] && ({way_tag[g], way_xbit[g]} == key);
    end
  endgenerate

  assign any_hit = |hit_vec;

  // lowest hitting way wins
  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/ltag_dbg_ctrl.sv
module ltag_dbg_ctrl
  import ltag_pkg::*;
#(
  parameter int WAYS = 2,
  parameter int SETS = 1024,
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SET_W   = $clog2(SETS),
  localparam int SET_LSB = TAG_LSB - SET_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        dbg_req,
  input  logic [1:0]                  dbg_cmd,
  input  logic [ADDR_W-1:0]           dbg_addr,
  input  logic [WORD_W-1:0]           dbg_wdata,
  input  logic [WAYS-1:0][TAG_W-1:0]  a_tag,
  input  logic [WAYS-1:0]             a_xbit,
  input  logic [WAYS-1:0]             a_vld,
  input  logic [WAYS-1:0][WORD_W-1:0] a_data,
  output logic [SET_W-1:0]            d_set,
  output logic [WAYS-1:0]             tag_we,
  output logic [WAYS-1:0]             data_we,
  output logic [TAG_W-1:0]            wr_tag,
  output logic                        wr_xbit,
  output logic                        wr_vld,
  output logic                        dbg_done,
  output logic [WORD_W-1:0]           dbg_rdata
);

  dir_e             dir;
  tgt_e             tgt;
  logic [WAY_W-1:0] way;
  logic [WORD_W-1:0] rd_word;
  logic             rd_fire;
  logic             unused_addr_bits;

  assign dir   = dir_e'(dbg_cmd[0]);
  assign tgt   = tgt_e'(dbg_cmd[1]);
  assign way   = dbg_addr[WAY_W-1:0];
  assign d_set = dbg_addr[SET_LSB +: SET_W];
  assign unused_addr_bits = ^{dbg_addr[ADDR_W-1:TAG_LSB], dbg_addr[SET_LSB-1:WAY_W]};

  assign wr_tag  = dbg_wdata[TAG_LSB +: TAG_W];
  assign wr_xbit = dbg_wdata[XBIT_POS];
  assign wr_vld  = dbg_wdata[0];

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_we
      assign tag_we[g]  = dbg_req && (dir == DIR_WRITE) && (tgt == TGT_TAG)  && (way == WAY_W'(g));
      assign data_we[g] = dbg_req && (dir == DIR_WRITE) && (tgt == TGT_DATA) && (way == WAY_W'(g));
    end
  endgenerate

  assign rd_fire = dbg_req && (dir == DIR_READ);

  always_comb begin
    if (tgt == TGT_TAG) begin
      rd_word = tag_image(a_tag[way], a_xbit[way], 2'(way), a_vld[way]);
    end else begin
      rd_word = a_data[way];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_done  <= 1'b0;
      dbg_rdata <= '0;
    end else begin
      dbg_done <= dbg_req;
      if (rd_fire) dbg_rdata <= rd_word;
    end
  end

endmodule

// File: rtl/ltag_lk_seq.sv
module ltag_lk_seq
  import ltag_pkg::*;
#(
  parameter int WAYS = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              dbg_req,
  input  logic              any_hit,
  input  logic [WAY_W-1:0]  hit_way,
  output logic [ADDR_W-1:0] srv_addr,
  output logic              serve,
  output logic              hold,
  output logic              lk_done,
  output logic              lk_hit,
  output logic [WAY_W-1:0]  lk_way
);

  logic              hold_q;
  logic [ADDR_W-1:0] hold_addr_q;
  logic              take_hold;

  // a held lookup is served next cycle; new requests in that cycle drop
  assign take_hold = lk_req && dbg_req && !hold_q;
  assign serve     = hold_q || (lk_req && !dbg_req);
  assign srv_addr  = hold_q ? hold_addr_q : lk_addr;
  assign hold      = hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q      <= 1'b0;
      hold_addr_q <= '0;
      lk_done     <= 1'b0;
      lk_hit      <= 1'b0;
      lk_way      <= '0;
    end else begin
      hold_q <= take_hold;
      if (take_hold) hold_addr_q <= lk_addr;
      lk_done <= serve;
      lk_hit  <= serve && any_hit;
      lk_way  <= (serve && any_hit) ? hit_way : '0;
    end
  end

endmodule

// File: rtl/ltag_array.sv
module ltag_array
  import ltag_pkg::*;
#(
  parameter int SETS = 1024,
  parameter int WAYS = 2,
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SET_W   = $clog2(SETS),
  localparam int SET_LSB = TAG_LSB - SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [31:0]       lk_addr,
  output logic              lk_done,
  output logic              lk_hit,
  output logic [WAY_W-1:0]  lk_way,
  input  logic              dbg_req,
  input  logic [1:0]        dbg_cmd,
  input  logic [31:0]       dbg_addr,
  input  logic [31:0]       dbg_wdata,
  output logic              dbg_done,
  output logic [31:0]       dbg_rdata
);

  logic [WAYS-1:0][TAG_W-1:0]  a_tag, b_tag;
  logic [WAYS-1:0]             a_xbit, a_vld, b_vld;
  logic [WAYS-1:0][WORD_W-1:0] a_data;
  logic [SET_W-1:0]            d_set, l_set;
  logic [WAYS-1:0]             tag_we, data_we;
  logic [TAG_W-1:0]            wr_tag;
  logic                        wr_xbit, wr_vld;
  logic [ADDR_W-1:0]           srv_addr;
  logic                        any_hit;
  logic [WAY_W-1:0]            hit_way;
  logic                        unused_srv_bits;

  // named internal events for the checker
  logic                        w_lk_hold;
  logic                        w_lk_serve;
  logic [WAYS-1:0]             w_hit_vec;
  logic [WAYS-1:0]             w_way_xbit;
  logic                        w_srv_set_msb;

  assign l_set           = srv_addr[SET_LSB +: SET_W];
  assign w_srv_set_msb   = l_set[SET_W-1];
  assign unused_srv_bits = ^srv_addr[SET_LSB-1:0];

  ltag_dbg_ctrl #(.WAYS(WAYS), .SETS(SETS)) u_dbg (
    .clk       (clk),
    .rst_n     (rst_n),
    .dbg_req   (dbg_req),
    .dbg_cmd   (dbg_cmd),
    .dbg_addr  (dbg_addr),
    .dbg_wdata (dbg_wdata),
    .a_tag     (a_tag),
    .a_xbit    (a_xbit),
    .a_vld     (a_vld),
    .a_data    (a_data),
    .d_set     (d_set),
    .tag_we    (tag_we),
    .data_we   (data_we),
    .wr_tag    (wr_tag),
    .wr_xbit   (wr_xbit),
    .wr_vld    (wr_vld),
    .dbg_done  (dbg_done),
    .dbg_rdata (dbg_rdata)
  );

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_bank
      ltag_way_bank #(.SETS(SETS), .TAG_W(TAG_W), .DW(WORD_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .tag_we  (tag_we[g]),
        .data_we (data_we[g]),
        .wr_set  (d_set),
        .wr_tag  (wr_tag),
        .wr_xbit (wr_xbit),
        .wr_vld  (wr_vld),
        .wr_data (dbg_wdata),
        .a_set   (d_set),
        .a_tag   (a_tag[g]),
        .a_xbit  (a_xbit[g]),
        .a_vld   (a_vld[g]),
        .a_data  (a_data[g]),
        .b_set   (l_set),
        .b_tag   (b_tag[g]),
        .b_xbit  (w_way_xbit[g]),
        .b_vld   (b_vld[g])
      );
    end
  endgenerate

  ltag_match #(.WAYS(WAYS)) u_match (
    .key      (addr_key(srv_addr)),
    .way_tag  (b_tag),
    .way_xbit (w_way_xbit),
    .way_vld  (b_vld),
    .hit_vec  (w_hit_vec),
    .any_hit  (any_hit),
    .hit_way  (hit_way)
  );

  ltag_lk_seq #(.WAYS(WAYS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_req   (lk_req),
    .lk_addr  (lk_addr),
    .dbg_req  (dbg_req),
    .any_hit  (any_hit),
    .hit_way  (hit_way),
    .srv_addr (srv_addr),
    .serve    (w_lk_serve),
    .hold     (w_lk_hold),
    .lk_done  (lk_done),
    .lk_hit   (lk_hit),
    .lk_way   (lk_way)
  );

endmodule

// File: rtl/ltag_array_chk.sv
module ltag_array_chk #(
  parameter int WAYS = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_req,
  input logic             lk_done,
  input logic             lk_hit,
  input logic [WAY_W-1:0] lk_way,
  input logic             dbg_req,
  input logic [1:0]       dbg_cmd,
  input logic             dbg_done,
  input logic [31:0]      dbg_rdata,
  input logic             w_lk_hold,
  input logic             w_lk_serve,
  input logic [WAYS-1:0]  w_hit_vec,
  input logic [WAYS-1:0]  w_way_xbit,
  input logic             w_srv_set_msb
);

  a_r3_done_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req |=> dbg_done);

  a_r3_done_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_done |-> $past(dbg_req));

  a_r3_tag_read_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_done && $past(dbg_cmd == 2'b00)) |-> (dbg_rdata[14:3] == 12'h000));

  a_r8_hit_needs_set_msb: assert property (@(posedge clk) disable iff (!rst_n)
    w_lk_serve |-> ((w_hit_vec & (w_way_xbit ^ {WAYS{w_srv_set_msb}})) == '0));

  a_r7_hit_from_served_match: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> $past(w_lk_serve && (w_hit_vec != '0)));

  a_r9_collision_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && dbg_req && !w_lk_hold) |=> (!lk_done && w_lk_hold));

  a_r9_held_is_served: assert property (@(posedge clk) disable iff (!rst_n)
    w_lk_hold |=> lk_done);

  a_r10_hold_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    w_lk_hold |=> !w_lk_hold);

  a_r11_hit_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_done);

  a_r11_way_zero_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_way == '0));

endmodule

bind ltag_array ltag_array_chk #(.WAYS(WAYS)) u_ltag_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .lk_req        (lk_req),
  .lk_done       (lk_done),
  .lk_hit        (lk_hit),
  .lk_way        (lk_way),
  .dbg_req       (dbg_req),
  .dbg_cmd       (dbg_cmd),
  .dbg_done      (dbg_done),
  .dbg_rdata     (dbg_rdata),
  .w_lk_hold     (w_lk_hold),
  .w_lk_serve    (w_lk_serve),
  .w_hit_vec     (w_hit_vec),
  .w_way_xbit    (w_way_xbit),
  .w_srv_set_msb (w_srv_set_msb)
);

// File: tb/test_ltag_array.sv
`timescale 1ns/1ps
module test_ltag_array;

  localparam int SETS = 1024;
  localparam int WAYS = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_done, lk_hit;
  logic [0:0]  lk_way;
  logic        dbg_req = 1'b0;
  logic [1:0]  dbg_cmd = '0;
  logic [31:0] dbg_addr = '0;
  logic [31:0] dbg_wdata = '0;
  logic        dbg_done;
  logic [31:0] dbg_rdata;

  always #2.5 clk = ~clk;

  ltag_array #(.SETS(SETS), .WAYS(WAYS)) i_ltag_array (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_addr(lk_addr), .lk_done(lk_done), .lk_hit(lk_hit), .lk_way(lk_way),
    .dbg_req(dbg_req), .dbg_cmd(dbg_cmd), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
    .dbg_done(dbg_done), .dbg_rdata(dbg_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [15:0] m_tag  [WAYS][SETS];
  logic        m_xbit [WAYS][SETS];
  logic        m_vld  [WAYS][SETS];
  bit          m_twr  [WAYS][SETS];
  bit          m_dwr  [WAYS][SETS];
  logic [31:0] m_data [WAYS][SETS];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // expected lookup result: bit1 hit, bit0 way (lowest way wins)
  function automatic logic [1:0] exp_lookup(input logic [31:0] a);
    logic [1:0] r = 2'b00;
    int s = int'(a[15:6]);
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (m_vld[w][s] === 1'b1 && m_tag[w][s] == a[31:16] && m_xbit[w][s] == a[15])
        r = {1'b1, 1'(w)};
    end
    return r;
  endfunction

  function automatic logic [31:0] dbg_addr_of(input int set, input int way);
    return {16'($urandom), 10'(set), 5'($urandom), 1'(way)};
  endfunction

  // cmd[0]: 0 read / 1 write; cmd[1]: 0 tag / 1 data (R5)
  task automatic dbg_access(input bit wr, input bit is_data, input int set, input int way,
                            input logic [31:0] wdata, input string req);
    logic [31:0] exp_w, mask;
    dbg_req = 1'b1; dbg_cmd = {is_data, wr};
    dbg_addr = dbg_addr_of(set, way); dbg_wdata = wdata;
    if (is_data) begin
      exp_w = m_data[way][set]; mask = m_dwr[way][set] ? 32'hFFFF_FFFF : 32'h0;
    end else begin
      exp_w = {m_tag[way][set], m_xbit[way][set], 12'h000, 2'(way), m_vld[way][set]};
      mask  = m_twr[way][set] ? 32'hFFFF_FFFF : 32'h0000_7FFF;
    end
    @(negedge clk);
    dbg_req = 1'b0;
    chk(dbg_done === 1'b1, {req, " done R3"}, 32'(dbg_done), 32'd1);
    if (!wr) chk((dbg_rdata & mask) === (exp_w & mask), {req, " read R5"}, dbg_rdata & mask, exp_w & mask);
    if (wr && is_data) begin
      m_data[way][set] = wdata; m_dwr[way][set] = 1'b1;
    end
    if (wr && !is_data) begin
      m_tag[way][set] = wdata[31:16]; m_xbit[way][set] = wdata[15];
      m_vld[way][set] = wdata[0]; m_twr[way][set] = 1'b1;
    end
  endtask

  task automatic lookup(input logic [31:0] a, input string req);
    logic [1:0] e;
    lk_req = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_req = 1'b0;
    e = exp_lookup(a);
    chk(lk_done === 1'b1, {req, " done"}, 32'(lk_done), 32'd1);
    chk(lk_hit === e[1], {req, " hit"}, 32'(lk_hit), 32'(e[1]));
    chk(lk_way === e[0], {req, " way R11"}, 32'(lk_way), 32'(e[0]));
  endtask

  // tag write colliding with a lookup; optionally a third lookup in the serve cycle
  task automatic collide(input int set, input int way, input logic [31:0] wdata,
                         input logic [31:0] a, input bit extra, input logic [31:0] b);
    logic [1:0] e;
    dbg_req = 1'b1; dbg_cmd = 2'b01; dbg_addr = dbg_addr_of(set, way); dbg_wdata = wdata;
    lk_req = 1'b1; lk_addr = a;
    @(negedge clk);
    dbg_req = 1'b0; lk_req = 1'b0;
    chk(dbg_done === 1'b1, "R9 debug first", 32'(dbg_done), 32'd1);
    chk(lk_done === 1'b0, "R9 lookup stalled", 32'(lk_done), 32'd0);
    m_tag[way][set] = wdata[31:16]; m_xbit[way][set] = wdata[15];
    m_vld[way][set] = wdata[0]; m_twr[way][set] = 1'b1;
    if (extra) begin lk_req = 1'b1; lk_addr = b; end
    @(negedge clk);
    lk_req = 1'b0;
    e = exp_lookup(a);
    chk(lk_done === 1'b1, "R9 held served", 32'(lk_done), 32'd1);
    chk(lk_hit === e[1], "R9 held sees write", 32'(lk_hit), 32'(e[1]));
    chk(lk_way === e[0], "R9 held way", 32'(lk_way), 32'(e[0]));
    if (extra) begin
      @(negedge clk);
      chk(lk_done === 1'b0, "R10 serve-cycle lookup dropped", 32'(lk_done), 32'd0);
    end
  endtask

  function automatic int rnd_set();
    case ($urandom_range(0, 5))
      0: return 0;
      1: return 511;
      2: return 512;
      3: return 1023;
      4: return 300;
      default: return 700;
    endcase
  endfunction

  function automatic logic [31:0] tag_word(input logic [15:0] t, input logic xb, input logic v);
    return {t, xb, 14'($urandom), v};
  endfunction

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7340));
    for (int w = 0; w < WAYS; w++)
      for (int s = 0; s < SETS; s++) begin
        m_vld[w][s] = 1'b0; m_twr[w][s] = 1'b0; m_dwr[w][s] = 1'b0;
      end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(dbg_done === 1'b0, "R1 dbg_done low", 32'(dbg_done), 32'd0);
    chk(lk_done === 1'b0, "R1 lk_done low", 32'(lk_done), 32'd0);
    chk(lk_hit === 1'b0, "R1 lk_hit low", 32'(lk_hit), 32'd0);
    lookup({16'h1234, 10'd512, 6'd0}, "R1 lookup after reset");
    dbg_access(1'b0, 1'b0, 512, 1, 32'h0, "R1 tag read invalid");

    // R2 R3 R4: write with junk in [14:1] and garbage address bits, read back
    dbg_access(1'b1, 1'b0, 512, 1, {16'h1234, 1'b1, 14'h3FFF, 1'b1}, "R2 tag write");
    dbg_access(1'b0, 1'b0, 512, 1, 32'h0, "R4 tag read other garbage");
    chk(dbg_rdata === 32'h1234_8003, "R3 tag image layout", dbg_rdata, 32'h1234_8003);
    lookup({16'h1234, 10'd512, 6'h3F}, "R7 hit way1");
    chk(lk_hit === 1'b1 && lk_way === 1'b1, "R7 directed hit", {30'd0, lk_hit, lk_way}, 32'd3);

    // R8: extra bit wrong for set 511 (MSB 0)
    dbg_access(1'b1, 1'b0, 511, 0, {16'h5555, 1'b1, 14'h0, 1'b1}, "R8 bad write");
    dbg_access(1'b0, 1'b0, 511, 0, 32'h0, "R8 readback");
    chk(dbg_rdata === 32'h5555_8001, "R8 bad entry readable", dbg_rdata, 32'h5555_8001);
    lookup({16'h5555, 10'd511, 6'd0}, "R8 bad entry");
    chk(lk_hit === 1'b0, "R8 bad entry never hits", 32'(lk_hit), 32'd0);
    dbg_access(1'b1, 1'b0, 511, 0, {16'h5555, 1'b0, 14'h0, 1'b1}, "R8 fixed write");
    lookup({16'h5555, 10'd511, 6'd0}, "R8 fixed entry");
    chk(lk_hit === 1'b1, "R8 fixed entry hits", 32'(lk_hit), 32'd1);

    // R7: both ways match, lowest wins
    dbg_access(1'b1, 1'b0, 700, 1, {16'h7777, 1'b1, 14'h0, 1'b1}, "R7 dup w1");
    dbg_access(1'b1, 1'b0, 700, 0, {16'h7777, 1'b1, 14'h0, 1'b1}, "R7 dup w0");
    lookup({16'h7777, 10'd700, 6'd5}, "R7 lowest way");
    chk(lk_way === 1'b0, "R7 lowest way wins", 32'(lk_way), 32'd0);

    // R6: data stub leaves tag alone
    dbg_access(1'b1, 1'b1, 512, 1, 32'hDEAD_BEEF, "R6 data write");
    dbg_access(1'b0, 1'b1, 512, 1, 32'h0, "R6 data read");
    chk(dbg_rdata === 32'hDEAD_BEEF, "R6 data value", dbg_rdata, 32'hDEAD_BEEF);
    dbg_access(1'b0, 1'b0, 512, 1, 32'h0, "R6 tag unchanged");
    lookup({16'h1234, 10'd512, 6'd0}, "R6 lookup unchanged");

    // R9 R10 directed
    collide(300, 0, {16'h0ABC, 1'b0, 14'h0, 1'b1}, {16'h0ABC, 10'd300, 6'd0},
            1'b1, {16'h1234, 10'd512, 6'd0});

    // R11 idle
    @(negedge clk);
    chk(lk_done === 1'b0 && lk_hit === 1'b0 && lk_way === 1'b0, "R11 idle outputs",
        {29'd0, lk_done, lk_hit, lk_way}, 32'd0);
    chk(dbg_done === 1'b0, "R3 done is one cycle", 32'(dbg_done), 32'd0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 9);
      int s = rnd_set();
      int w = $urandom_range(0, 1);
      logic [15:0] t = 16'hA000 + 16'($urandom_range(0, 3));
      logic xb = s[9] ^ ($urandom_range(0, 3) == 0);
      case (op)
        0, 1, 2: dbg_access(1'b1, 1'b0, s, w, tag_word(t, xb, 1'($urandom_range(0, 5) != 0)), "R2 rnd write");
        3: dbg_access(1'b0, 1'b0, s, w, 32'h0, "R3 rnd tag read");
        4: dbg_access(1'b1, 1'b1, s, w, $urandom, "R6 rnd data write");
        5: dbg_access(1'b0, 1'b1, s, w, 32'h0, "R6 rnd data read");
        6, 7, 8: lookup({t, 10'(s), 6'($urandom)}, "R7 rnd lookup");
        default: collide(s, w, tag_word(t, xb, 1'b1), {t, 10'(s), 6'($urandom)},
                         1'($urandom), {16'hA000, 10'(rnd_set()), 6'd0});
      endcase
    end

    finished = 1;
    report();
    $finish;
  end

endmodule